// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs single-lane serial flash operations for a host. The host writes a mask of one-shot trigger bits, one bit per operation. The sequencer picks one pending operation and drives chip select and the serial clock enable. It shifts the opcode out, then a 24-bit address when the operation has one, then moves the data bytes in or out. Read bytes go into a host-side buffer port and write bytes come from one. The trigger bit of an operation drops by itself once that operation is finished, so software can poll the bit to see when it is done.

One serial bit is moved in every system clock cycle in which `sck_en` is high. The serial clock is the system clock gated by `sck_en`. `mosi` holds a bit for the whole cycle, and `miso` is taken at the end of the cycle. Bit order is MSB first, as in mode 0. A single 32-bit word carries both the flash address and the transfer length. A 3-bit state field lets the host watch the sequencer step through its phases. After each operation, a programmable hold time passes before the sequencer reports idle again.

Top module: `serial_flash_seq`

## Requirements
- R1: A host write (`cmd_wr` high) made while the block is not busy ORs `cmd_wdata` into the pending trigger bits, and `cmd_bits` shows them from the next cycle on. Bit meanings: 0 read data, 1 write enable, 2 write disable, 3 read ID, 4 read status, 5 write status, 6 page program, 7 4 KB sector erase, 8 32 KB block erase, 9 chip erase, 10 deep power-down, 11 wake from power-down with ID read, 12 high-performance mode.
- R2: When several trigger bits are pending, the operation with the lowest bit index runs first. The other bits stay pending and run afterwards, one at a time.
- R3: A write made while `busy` is high changes no pending bit. `busy` is high while any bit is pending or the sequencer is not idle.
- R4: The trigger bit of an operation stays set through its done state and is clear from the cycle after that state.
- R5: `state` reads 0 idle, 1 preparation, 2 opcode, 3 address, 4 read data, 5 write data, 6 wait, 7 done. Preparation lasts 1 cycle and the opcode phase lasts 8 cycles. The address phase lasts 24 cycles or is skipped. The data phases last 8 cycles per byte.
- R6: The opcode goes out MSB first on `mosi`. Opcodes by bit index: 0→0x03, 1→0x06, 2→0x04, 3→0x9F, 4→0x05, 5→0x01, 6→0x02, 7→0x20, 8→0x52, 9→0xC7, 10→0xB9, 11→0xAB, 12→0xA3.
- R7: Read data, page program, sector erase and block erase send `addr_word[23:0]` MSB first after the opcode. Wake and high-performance mode send 24 zero bits in that place. The other operations send no address.
- R8: Read data takes `addr_word[31:24]`+1 bytes. Read ID takes 3 bytes. Read status and wake take 1 byte. Each byte is assembled MSB first and written once on `rbuf_we` at indices 0, 1, 2 and so on.
- R9: Page program sends `addr_word[31:24]`+1 bytes (1 to 256), and write status sends 1 byte. Both take their bytes from the write buffer at indices 0, 1, 2 and so on, MSB first.
- R10: `cs_n` goes low once per operation. It stays low from the first opcode bit to the last data bit. `sck_en` is high only while `cs_n` is low, exactly once for each bit moved.
- R11: After the done state, the sequencer spends `hold_dly` cycles in the wait state before idle. A `hold_dly` of zero goes straight to idle.
- R12: After reset, nothing is pending, `state` is 0, `busy` and `sck_en` are low and `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the trigger mask |
| cmd_wdata | input | 13 | Trigger bits to set |
| cmd_bits | output | 13 | Pending trigger bits, self-clearing |
| addr_word | input | 32 | [23:0] flash address, [31:24] byte count minus one |
| hold_dly | input | 12 | Wait cycles after done |
| busy | output | 1 | Operation pending or running |
| state | output | 3 | Sequencer phase code |
| wbuf_idx | output | 8 | Index of the next write byte |
| wbuf_data | input | 8 | Write buffer byte at `wbuf_idx` |
| rbuf_we | output | 1 | Read byte strobe |
| rbuf_idx | output | 8 | Read byte index |
| rbuf_data | output | 8 | Read byte value |
| cs_n | output | 1 | Flash chip select, active low |
| sck_en | output | 1 | Serial clock enable for this cycle |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
Some properties are checked on every cycle. `sck_en` never runs with chip select high, and chip select rises only into the done state. Pending bits do not move while the block is busy, and a completed bit is gone the cycle after done. The operation in preparation is always the lowest pending one, and a nonzero wait count keeps the sequencer waiting. Other behaviour shows only in the bench's scenarios: the bit streams on `mosi` for each opcode, address and payload, the bytes assembled from `miso`, the exact phase dwell times, and the measured hold time.

// File: rtl/sfs_pkg.sv
// Shared types for the serial flash sequencer: phase codes, per-operation
// descriptor, and the table that maps a trigger index to its descriptor.
// Assumes 13 operations, indexed as listed in the brief.
package sfs_pkg;

    localparam int NCMD = 13;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_CMD  = 3'd2,
        ST_ADDR = 3'd3,
        ST_RDAT = 3'd4,
        ST_WDAT = 3'd5,
        ST_WAIT = 3'd6,
        ST_DONE = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RX   = 2'd1,
        DIR_TX   = 2'd2
    } data_dir_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       has_addr;
        logic       addr_zero;
        data_dir_e  dir;
        logic       use_len;
        logic [7:0] fix_len;   // bytes minus one when use_len is low
    } cmd_info_t;

    // Descriptor for one trigger index.
    function automatic cmd_info_t cmd_lookup(input logic [3:0] idx);
        cmd_info_t c;
        c.opcode    = 8'h00;
        c.has_addr  = 1'b0;
        c.addr_zero = 1'b0;
        c.dir       = DIR_NONE;
        c.use_len   = 1'b0;
        c.fix_len   = 8'd0;
        case (idx)
            4'd0:  begin c.opcode = 8'h03; c.has_addr = 1'b1; c.dir = DIR_RX; c.use_len = 1'b1; end
            4'd1:  c.opcode = 8'h06;
            4'd2:  c.opcode = 8'h04;
            4'd3:  begin c.opcode = 8'h9F; c.dir = DIR_RX; c.fix_len = 8'd2; end
            4'd4:  begin c.opcode = 8'h05; c.dir = DIR_RX; end
            4'd5:  begin c.opcode = 8'h01; c.dir = DIR_TX; end
            4'd6:  begin c.opcode = 8'h02; c.has_addr = 1'b1; c.dir = DIR_TX; c.use_len = 1'b1; end
            4'd7:  begin c.opcode = 8'h20; c.has_addr = 1'b1; end
            4'd8:  begin c.opcode = 8'h52; c.has_addr = 1'b1; end
            4'd9:  c.opcode = 8'hC7;
            4'd10: c.opcode = 8'hB9;
            4'd11: begin c.opcode = 8'hAB; c.has_addr = 1'b1; c.addr_zero = 1'b1; c.dir = DIR_RX; end
            4'd12: begin c.opcode = 8'hA3; c.has_addr = 1'b1; c.addr_zero = 1'b1; end
            default: c.opcode = 8'h00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfs_arbiter.sv
// Fixed-priority picker: grants the lowest set request bit.
// Purely combinational; assumes the caller registers the chosen index.
module sfs_arbiter #(
    parameter int N  = 13,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Priority chain: a bit wins only if no lower bit is set.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];

    // Encode the one-hot grant into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/sfs_shifter.sv
// Serial data path: a W-bit transmit register shifted MSB first and a
// 7-bit receive history; the current miso bit completes a received byte.
// Assumes W >= 8 and that load has priority over shift.
module sfs_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         miso,
    output logic         tx_bit,
    output logic [7:0]   rx_byte
);

    logic [W-1:0] tx_q;
    logic [6:0]   rx_q;

    // Transmit register: load a new word or shift one bit toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (load)  tx_q <= load_val;
        else if (shift) tx_q <= {tx_q[W-2:0], 1'b0};
    end

    // Receive history: keep the last seven sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_q <= '0;
        else if (sample) rx_q <= {rx_q[5:0], miso};
    end

    assign tx_bit  = tx_q[W-1];
    assign rx_byte = {rx_q, miso};

endmodule

// File: rtl/serial_flash_seq.sv
// Serial flash command sequencer. Holds self-clearing trigger bits, runs
// the lowest pending one as opcode / address / data phases on a single
// lane, then waits hold_dly cycles before idle. Assumes one serial bit per
// clk cycle, with the host buffers answering combinationally.
module serial_flash_seq
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 8,
    parameter int HOLD_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [NCMD-1:0]         cmd_wdata,
    output logic [NCMD-1:0]         cmd_bits,
    input  logic [ADDR_W+LEN_W-1:0] addr_word,
    input  logic [HOLD_W-1:0]       hold_dly,
    output logic                    busy,
    output logic [2:0]              state,
    output logic [LEN_W-1:0]        wbuf_idx,
    input  logic [7:0]              wbuf_data,
    output logic                    rbuf_we,
    output logic [LEN_W-1:0]        rbuf_idx,
    output logic [7:0]              rbuf_data,
    output logic                    cs_n,
    output logic                    sck_en,
    output logic                    mosi,
    input  logic                    miso
);

    localparam int IW  = $clog2(NCMD);
    localparam int CW  = (HOLD_W > LEN_W + 3) ? HOLD_W : LEN_W + 3;
    localparam int PAD = ADDR_W - 8;

    seq_state_e        state_q;
    logic [NCMD-1:0]   pend_q;
    logic [IW-1:0]     sel_q;
    cmd_info_t         info_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  nb_q;
    logic [CW-1:0]     cnt_q;
    logic [LEN_W-1:0]  widx_q;
    logic [LEN_W-1:0]  ridx_q;
    logic              cs_q;

    logic              arb_any;
    logic [IW-1:0]     arb_idx;
    logic [NCMD-1:0]   arb_grant;
    cmd_info_t         info_new;

    seq_state_e        data_st;
    logic [CW-1:0]     data_cnt;
    logic              phase_end;
    logic              ld_op, ld_addr, ld_byte, sh_load, tx_active, rd_active;
    logic [ADDR_W-1:0] sh_val;
    logic              tx_bit;
    logic [7:0]        rx_byte;

    sfs_arbiter #(.N(NCMD), .IW(IW)) u_arb (
        .req   (pend_q),
        .any   (arb_any),
        .idx   (arb_idx),
        .grant (arb_grant)
    );

    assign info_new  = cmd_lookup(4'(arb_idx));
    assign phase_end = (cnt_q == '0);
    assign tx_active = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_WDAT);
    assign rd_active = (state_q == ST_RDAT);

    // Pick the phase that follows the address or opcode phase.
    always_comb begin
        case (info_q.dir)
            DIR_RX:  data_st = ST_RDAT;
            DIR_TX:  data_st = ST_WDAT;
            default: data_st = ST_DONE;
        endcase
    end

    assign data_cnt = CW'({nb_q, 3'b111});

    // Decide when the transmit register takes a new opcode, address or byte.
    always_comb begin
        ld_op   = (state_q == ST_IDLE) && arb_any;
        ld_addr = (state_q == ST_CMD) && phase_end && info_q.has_addr;
        ld_byte = ((info_q.dir == DIR_TX) && phase_end &&
                   (((state_q == ST_CMD) && !info_q.has_addr) || (state_q == ST_ADDR))) ||
                  ((state_q == ST_WDAT) && (cnt_q[2:0] == 3'd0) && !phase_end);
        sh_load = ld_op || ld_addr || ld_byte;
        if (ld_op)        sh_val = {info_new.opcode, {PAD{1'b0}}};
        else if (ld_addr) sh_val = addr_q;
        else              sh_val = {wbuf_data, {PAD{1'b0}}};
    end

    sfs_shifter #(.W(ADDR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (tx_active),
        .sample   (rd_active),
        .miso     (miso),
        .tx_bit   (tx_bit),
        .rx_byte  (rx_byte)
    );

    assign rbuf_we = rd_active && (cnt_q[2:0] == 3'd0);

    // Sequencer: trigger capture, phase stepping, completion and hold wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            sel_q   <= '0;
            info_q  <= '0;
            addr_q  <= '0;
            nb_q    <= '0;
            cnt_q   <= '0;
            widx_q  <= '0;
            ridx_q  <= '0;
            cs_q    <= 1'b1;
        end else begin
            if (cmd_wr && !busy) pend_q <= pend_q | cmd_wdata;
            if (ld_byte) widx_q <= widx_q + 1'b1;
            if (rbuf_we) ridx_q <= ridx_q + 1'b1;
            case (state_q)
                ST_IDLE: if (arb_any) begin
                    state_q <= ST_PREP;
                    sel_q   <= arb_idx;
                    info_q  <= info_new;
                    addr_q  <= info_new.addr_zero ? '0 : addr_word[ADDR_W-1:0];
                    nb_q    <= info_new.use_len ? addr_word[ADDR_W +: LEN_W]
                                                : LEN_W'(info_new.fix_len);
                    widx_q  <= '0;
                    ridx_q  <= '0;
                end
                ST_PREP: begin
                    state_q <= ST_CMD;
                    cnt_q   <= CW'(7);
                    cs_q    <= 1'b0;
                end
                ST_CMD: if (!phase_end) cnt_q <= cnt_q - 1'b1;
                    else if (info_q.has_addr) begin
                        state_q <= ST_ADDR;
                        cnt_q   <= CW'(ADDR_W - 1);
                    end else begin
                        state_q <= data_st;
                        cnt_q   <= data_cnt;
                        if (data_st == ST_DONE) cs_q <= 1'b1;
                    end
                ST_ADDR: if (!phase_end) cnt_q <= cnt_q - 1'b1;
                    else begin
                        state_q <= data_st;
                        cnt_q   <= data_cnt;
                        if (data_st == ST_DONE) cs_q <= 1'b1;
                    end
                ST_RDAT, ST_WDAT: if (!phase_end) cnt_q <= cnt_q - 1'b1;
                    else begin
                        state_q <= ST_DONE;
                        cs_q    <= 1'b1;
                    end
                ST_DONE: begin
                    pend_q[sel_q] <= 1'b0;
                    if (hold_dly == '0) state_q <= ST_IDLE;
                    else begin
                        state_q <= ST_WAIT;
                        cnt_q   <= CW'(hold_dly) - CW'(1);
                    end
                end
                ST_WAIT: if (phase_end) state_q <= ST_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_bits  = pend_q;
    assign busy      = (state_q != ST_IDLE) || (|pend_q);
    assign state     = state_q;
    assign wbuf_idx  = widx_q;
    assign rbuf_idx  = ridx_q;
    assign rbuf_data = rx_byte;
    assign cs_n      = cs_q;
    assign sck_en    = tx_active || rd_active;
    assign mosi      = tx_active ? tx_bit : 1'b0;

    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_any |-> ($countones(arb_grant) == 1)); // R2
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREP) |-> (pend_q[sel_q] &&
            ((pend_q & ((NCMD'(1) << sel_q) - NCMD'(1))) == '0))); // R2
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && state_q != ST_DONE) |=> (pend_q == $past(pend_q))); // R3
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> !pend_q[$past(sel_q)]); // R4
    AST_SCK_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sck_en |-> !cs_n); // R10
    AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (state_q == ST_DONE)); // R10
    AST_RBUF_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rbuf_we |-> (info_q.dir == DIR_RX)); // R8
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cnt_q != '0) |=> (state_q == ST_WAIT)); // R11

endmodule

// File: tb/serial_flash_seq_tb_top.sv
// Bench for serial_flash_seq: a flash stand-in captures mosi and drives
// miso from a random byte source; each operation is checked for stream
// content, phase dwell, buffer traffic, bit clearing and hold timing.
module serial_flash_seq_tb_top;

    localparam int N = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [N-1:0]  cmd_wdata = '0;
    logic [N-1:0]  cmd_bits;
    logic [31:0]   addr_word = '0;
    logic [11:0]   hold_dly = '0;
    logic          busy;
    logic [2:0]    state;
    logic [7:0]    wbuf_idx, wbuf_data, rbuf_idx, rbuf_data;
    logic          rbuf_we, cs_n, sck_en, mosi;
    logic          miso = 1'b0;

    logic [7:0]    wmem [256];
    logic [7:0]    rdsrc[256];
    logic [7:0]    rmem [256];
    bit            cap  [2100];
    int            k = 0, hdr = 8, rwr = 0, cs_segs = 0;
    bit            prev_cs = 1'b1;
    int            n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    assign wbuf_data = wmem[wbuf_idx];

    serial_flash_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_bits(cmd_bits), .addr_word(addr_word), .hold_dly(hold_dly),
        .busy(busy), .state(state), .wbuf_idx(wbuf_idx), .wbuf_data(wbuf_data),
        .rbuf_we(rbuf_we), .rbuf_idx(rbuf_idx), .rbuf_data(rbuf_data),
        .cs_n(cs_n), .sck_en(sck_en), .mosi(mosi), .miso(miso)
    );

    // Flash stand-in: capture mosi bits and read bytes mid-cycle.
    initial forever begin
        @(negedge clk);
        if (prev_cs && !cs_n) cs_segs++;
        prev_cs = cs_n;
        if (!cs_n && sck_en) begin
            if (k < 2100) cap[k] = mosi;
            k++;
        end
        if (rbuf_we) begin
            rmem[rbuf_idx] = rbuf_data;
            rwr++;
        end
    end

    // Flash stand-in: drive miso shortly after each rising edge.
    initial forever begin
        @(posedge clk);
        #1;
        if (k >= hdr && (k - hdr) < 2048) miso = rdsrc[(k - hdr) / 8][7 - ((k - hdr) % 8)];
        else miso = 1'b0;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int f_op(input int i);
        case (i)
            0: return 8'h03;  1: return 8'h06;  2: return 8'h04;  3: return 8'h9F;
            4: return 8'h05;  5: return 8'h01;  6: return 8'h02;  7: return 8'h20;
            8: return 8'h52;  9: return 8'hC7; 10: return 8'hB9; 11: return 8'hAB;
            default: return 8'hA3;
        endcase
    endfunction

    function automatic bit f_addr(input int i);
        return (i == 0) || (i == 6) || (i == 7) || (i == 8) || (i == 11) || (i == 12);
    endfunction

    // 1 = read data in, 2 = write data out, 0 = none
    function automatic int f_dir(input int i);
        if (i == 0 || i == 3 || i == 4 || i == 11) return 1;
        if (i == 5 || i == 6) return 2;
        return 0;
    endfunction

    function automatic int f_len(input int i, input int lf);
        case (i)
            0, 6:      return lf + 1;
            3:         return 3;
            4, 5, 11:  return 1;
            default:   return 0;
        endcase
    endfunction

    task automatic prep_op(input int idx);
        hdr = 8 + (f_addr(idx) ? 24 : 0);
        k = 0;
        cs_segs = 0;
        rwr = 0;
        for (int i = 0; i < 256; i++) rdsrc[i] = 8'($urandom);
    endtask

    task automatic issue(input logic [N-1:0] bits);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = bits;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_wdata = '0;
    endtask

    task automatic finish_op(input int idx, input logic [N-1:0] rest, input bit dwell);
        int dw[8];
        int n, ab, dir, w, bad_i;
        logic [7:0] got;
        logic [23:0] ga, ea;
        n   = f_len(idx, int'(addr_word[31:24]));
        ab  = f_addr(idx) ? 24 : 0;
        dir = f_dir(idx);
        foreach (dw[i]) dw[i] = 0;
        while (state != 3'd7) begin
            dw[state]++;
            @(negedge clk);
        end
        if (dwell) begin
            chk(dw[1] == 1 && dw[2] == 8, "R5 prep/opcode dwell", dw[1] * 100 + dw[2], 108);
            chk(dw[3] == ab, "R5 address dwell", dw[3], ab);
            chk(dw[4] == (dir == 1 ? n * 8 : 0) && dw[5] == (dir == 2 ? n * 8 : 0),
                "R5 data dwell", dw[4] * 10000 + dw[5],
                (dir == 1 ? n * 80000 : 0) + (dir == 2 ? n * 8 : 0));
        end
        for (int b = 0; b < 8; b++) got[7 - b] = cap[b];
        chk(got == 8'(f_op(idx)), "R6 opcode", got, f_op(idx));
        if (ab != 0) begin
            for (int b = 0; b < 24; b++) ga[23 - b] = cap[8 + b];
            ea = (idx == 11 || idx == 12) ? 24'd0 : addr_word[23:0];
            chk(ga == ea, "R7 address bits", ga, ea);
        end
        chk(k == 8 + ab + n * 8 && cs_segs == 1, "R10 bit count / one cs window",
            k * 10 + cs_segs, (8 + ab + n * 8) * 10 + 1);
        if (dir == 2) begin
            bad_i = -1;
            for (int j = 0; j < n; j++) begin
                for (int b = 0; b < 8; b++) got[7 - b] = cap[hdr + j * 8 + b];
                if (got != wmem[j] && bad_i < 0) bad_i = j;
            end
            chk(bad_i < 0, "R9 write payload (first bad byte index)", bad_i, -1);
        end
        if (dir == 1) begin
            bad_i = -1;
            for (int j = 0; j < n; j++) if (rmem[j] != rdsrc[j] && bad_i < 0) bad_i = j;
            chk(bad_i < 0 && rwr == n, "R8 read bytes (first bad index / writes)",
                bad_i * 1000 + rwr, -1000 + n);
        end
        chk(cmd_bits[idx] && busy, "R4 bit held through done", {31'd0, cmd_bits[idx]}, 1);
        @(negedge clk);
        chk(cmd_bits == rest, "R4 self-clear", cmd_bits, rest);
        w = 0;
        while (state == 3'd6) begin
            if (!busy) chk(1'b0, "R11 busy during wait", 0, 1);
            w++;
            @(negedge clk);
        end
        chk(w == int'(hold_dly), "R11 hold delay", w, hold_dly);
        if (rest == '0)
            chk(state == 3'd0 && !busy && cs_n, "R11 idle after hold", {29'd0, state}, 0);
    endtask

    task automatic run_one(input int idx, input int lf, input logic [23:0] a, input int hold);
        addr_word = {8'(lf), a};
        hold_dly  = 12'(hold);
        for (int i = 0; i < 256; i++) wmem[i] = 8'($urandom);
        prep_op(idx);
        issue(N'(1) << idx);
        chk(cmd_bits == (N'(1) << idx), "R1 trigger captured", cmd_bits, N'(1) << idx);
        finish_op(idx, '0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int idx, lf;
        void'($urandom(32'h5EED_0001));
        for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(cmd_bits == '0 && state == 3'd0 && !busy && cs_n && !sck_en,
            "R12 reset state", {cmd_bits, state, busy, cs_n, sck_en}, 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: one of each operation.
        for (int i = 0; i < N; i++) run_one(i, 3, 24'hA5C3_0F, 2);
        // Directed boundaries: full page, single byte, zero and long hold.
        run_one(6, 255, 24'h12_3456, 0);
        run_one(0, 0, 24'hFF_FFFF, 0);
        run_one(0, 255, 24'h00_0001, 37);
        run_one(5, 0, 24'h00_0000, 1);

        // Directed R2: two bits at once, lower index first.
        addr_word = 32'h0000_1234;
        hold_dly  = 12'd3;
        prep_op(1);
        issue((N'(1) << 7) | (N'(1) << 1));
        chk(cmd_bits == ((N'(1) << 7) | (N'(1) << 1)), "R1 two bits captured", cmd_bits, 13'h0082);
        finish_op(1, N'(1) << 7, 1'b1);
        prep_op(7);
        finish_op(7, '0, 1'b1);

        // Directed R3: a write during the opcode phase is ignored.
        addr_word = 32'h0200_4000;
        hold_dly  = 12'd2;
        for (int i = 0; i < 256; i++) wmem[i] = 8'($urandom);
        prep_op(6);
        issue(N'(1) << 6);
        while (state != 3'd2) @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = N'(1) << 9;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_wdata = '0;
        chk(cmd_bits == (N'(1) << 6), "R3 write while busy ignored", cmd_bits, N'(1) << 6);
        finish_op(6, '0, 1'b0);

        // Random operations.
        for (int r = 0; r < 40; r++) begin
            idx = int'($urandom % N);
            lf  = (idx == 0 || idx == 6) ? int'($urandom % 32) : int'($urandom % 256);
            run_one(idx, lf, 24'($urandom), int'($urandom % 16));
        end

        summary();
        $finish;
    end

endmodule